// File: doc/BRIEF.md
# Successive Approximation Converter Sequencer

This block is the digital half of a successive approximation analog-to-digital converter. It drives a trial code to an external digital-to-analog converter, samples a single comparator bit each clock, and narrows the trial by binary search until every bit of the result is known. The analog parts stay outside the block. In the bench, a behavioural comparison of the trial code against a stored target value stands in for them.

A host starts a conversion with a one-cycle strobe and watches a ready flag. When the flag returns high, the finished code sits in a result register. A read-enable input places that code on a registered data bus. Every bit decision is also sent out serially, with a valid strobe, in the clock after it is made. Only one conversion runs at a time. The conversion length does not depend on the input: it is always WIDTH clocks.

Top module: `sar_adc_ctrl`

## Requirements
- R1: When a start strobe is accepted, the DAC code in the next cycle has only the most significant bit set.
- R2: The comparator bit is sampled at the end of each bit cycle, and 1 means the input is at or above the trial code. A 1 keeps the tested bit. A 0 clears it. In both cases the next lower bit is set for the next trial. At completion the DAC code equals the final result, which is the largest code not above the input.
- R3: A conversion takes exactly WIDTH clocks whatever the input, so ready is low for exactly WIDTH cycles.
- R4: Bits are decided one per clock, from the most significant bit down to the least significant. Serial valid pulses high in each of the WIDTH cycles after a decision and is low otherwise.
- R5: While serial valid is high, the serial bit equals the comparator value sampled at the decision edge. This value is the decided bit.
- R6: A start strobe that arrives while ready is low is ignored. This includes a strobe on the edge that resolves the last bit. The conversion keeps its length and no new conversion follows.
- R7: Ready goes low on the clock after an accepted start. It returns high in the cycle in which the least significant decision is latched.
- R8: The result register changes only when a conversion completes. It holds its value across idle periods and target changes.
- R9: Data out is registered. It shows the result register in the cycle after rd_i is sampled high, and zero in the cycle after rd_i is sampled low.
- R10: While reset is high, ready is 1 and the DAC code, data out and serial valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Conversion start strobe |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the DAC code |
| rd_i | input | 1 | Read enable for the result bus |
| dac_code_o | output | WIDTH | Trial code to the external DAC |
| ready_o | output | 1 | High when idle with a valid result |
| data_o | output | WIDTH | Registered result bus, zero unless read |
| serial_bit_o | output | 1 | Most recently decided bit |
| serial_valid_o | output | 1 | Qualifies serial_bit_o |

## Verification
The first trial code and the falling ready flag appear one clock after the start edge. Each bit decision, and its serial copy, appears one clock after the edge that samples the comparator. The final code and the rising ready flag appear WIDTH clocks after the start edge, and read data appears one clock after rd_i is sampled. A behavioural model in the bench advances on each rising edge using only the bench's own inputs and its own state, and the bench compares all outputs against it on the falling edge. Directed tasks also count the low-ready cycles per conversion, strobe start in mid-conversion and on the final edge, and read the result back against the target.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_CONV = 1'b1
  } seq_state_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic load_o,
  output logic last_o
);
  localparam int IDXW = idx_width(WIDTH);
  localparam logic [IDXW-1:0] TOP_IDX = IDXW'(WIDTH - 1);

  seq_state_e      state_q;
  logic [IDXW-1:0] idx_q;

  assign busy_o = (state_q == SEQ_CONV);
  assign load_o = (state_q == SEQ_IDLE) && start_i;
  assign last_o = (state_q == SEQ_CONV) && (idx_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            state_q <= SEQ_CONV;
            idx_q   <= TOP_IDX;
          end
        end
        SEQ_CONV: begin
          if (idx_q == '0) begin
            state_q <= SEQ_IDLE;
          end else begin
            idx_q <= idx_q - 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] code_o,
  output logic [WIDTH-1:0] next_o,
  output logic             ser_bit_o,
  output logic             ser_vld_o
);
  localparam logic [WIDTH-1:0] HALF_SCALE = WIDTH'(1) << (WIDTH - 1);

  logic [WIDTH-1:0] code_q;
  logic [WIDTH-1:0] weight_q;
  logic [WIDTH-1:0] kept;

  // Keep or drop the weight under test, then try the next lower one.
  assign kept   = cmp_i ? code_q : (code_q & ~weight_q);
  assign next_o = kept | (weight_q >> 1);
  assign code_o = code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q    <= '0;
      weight_q  <= '0;
      ser_bit_o <= 1'b0;
      ser_vld_o <= 1'b0;
    end else begin
      ser_vld_o <= step_i;
      if (step_i) begin
        ser_bit_o <= cmp_i;
      end
      if (load_i) begin
        code_q   <= HALF_SCALE;
        weight_q <= HALF_SCALE;
      end else if (step_i) begin
        code_q   <= next_o;
        weight_q <= weight_q >> 1;
      end
    end
  end
endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture_i,
  input  logic [WIDTH-1:0] value_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] result_o,
  output logic [WIDTH-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      data_o   <= '0;
    end else begin
      if (capture_i) begin
        result_o <= value_i;
      end
      data_o <= rd_i ? result_o : '0;
    end
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             cmp_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic             ready_o,
  output logic [WIDTH-1:0] data_o,
  output logic             serial_bit_o,
  output logic             serial_valid_o
);
  logic             busy;
  logic             load;
  logic             last;
  logic [WIDTH-1:0] next_code;
  logic [WIDTH-1:0] result_w;

  sar_seq #(.WIDTH(WIDTH)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy),
    .load_o  (load),
    .last_o  (last)
  );

  sar_trial #(.WIDTH(WIDTH)) u_trial (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load),
    .step_i    (busy),
    .cmp_i     (cmp_i),
    .code_o    (dac_code_o),
    .next_o    (next_code),
    .ser_bit_o (serial_bit_o),
    .ser_vld_o (serial_valid_o)
  );

  sar_result #(.WIDTH(WIDTH)) u_result (
    .clk       (clk),
    .rst       (rst),
    .capture_i (last),
    .value_i   (next_code),
    .rd_i      (rd_i),
    .result_o  (result_w),
    .data_o    (data_o)
  );

  assign ready_o = ~busy;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             cmp_i,
  input logic             rd_i,
  input logic [WIDTH-1:0] dac_code_o,
  input logic             ready_o,
  input logic [WIDTH-1:0] data_o,
  input logic             serial_bit_o,
  input logic             serial_valid_o,
  input logic [WIDTH-1:0] result_w
);
  localparam int CW = $clog2(WIDTH + 2) + 1;
  localparam logic [WIDTH-1:0] HALF_SCALE = WIDTH'(1) << (WIDTH - 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) low_cnt <= '0;
    else if (!ready_o) low_cnt <= low_cnt + 1'b1;
    else low_cnt <= '0;
  end

  // R1 and R7: first trial is half scale, ready drops
  p_first_trial_r1: assert property (@(posedge clk) disable iff (rst)
    (start_i && ready_o) |=> ((dac_code_o == HALF_SCALE) && !ready_o));

  // R3 and R6: every conversion spans exactly WIDTH low-ready cycles
  p_length_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> (low_cnt == CW'(WIDTH)));

  // R4: a serial strobe only follows a busy cycle
  p_valid_busy_r4: assert property (@(posedge clk) disable iff (rst)
    serial_valid_o |-> $past(!ready_o));

  // R5: serial bit carries the sampled comparator decision
  p_serial_bit_r5: assert property (@(posedge clk) disable iff (rst)
    serial_valid_o |-> (serial_bit_o == $past(cmp_i)));

  // R8: result changes only together with completion
  p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$rose(ready_o) |-> $stable(result_w));

  // R9: bus is zero after a cycle without read enable
  p_bus_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_i) |-> (data_o == '0));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.WIDTH(WIDTH)) i_chk (
  .clk            (clk),
  .rst            (rst),
  .start_i        (start_i),
  .cmp_i          (cmp_i),
  .rd_i           (rd_i),
  .dac_code_o     (dac_code_o),
  .ready_o        (ready_o),
  .data_o         (data_o),
  .serial_bit_o   (serial_bit_o),
  .serial_valid_o (serial_valid_o),
  .result_w       (result_w)
);

// File: tb/test_sar_adc_ctrl.sv
module test_sar_adc_ctrl;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic rd_i = 1'b0;
  logic cmp_i;
  logic [W-1:0] target = '0;
  logic [W-1:0] dac_code_o;
  logic [W-1:0] data_o;
  logic ready_o, serial_bit_o, serial_valid_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  // Behavioural stand-in for the DAC plus comparator
  assign cmp_i = (target >= dac_code_o);

  sar_adc_ctrl #(.WIDTH(W)) i_sar_adc_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .cmp_i(cmp_i), .rd_i(rd_i),
    .dac_code_o(dac_code_o), .ready_o(ready_o), .data_o(data_o),
    .serial_bit_o(serial_bit_o), .serial_valid_o(serial_valid_o)
  );

  // Reference model: advances on the rising edge from bench inputs only
  int m_busy, m_idx, m_code, m_result, m_data, m_sv, m_sb;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_idx = 0; m_code = 0; m_result = 0;
      m_data = 0; m_sv = 0; m_sb = 0;
    end else begin
      m_data = rd_i ? m_result : 0;
      m_sv = 0;
      if (m_busy != 0) begin
        int c;
        c = (int'(target) >= m_code) ? 1 : 0;
        m_sb = c;
        m_sv = 1;
        if (c == 0) m_code = m_code - (1 << m_idx);
        if (m_idx > 0) begin
          m_code = m_code + (1 << (m_idx - 1));
          m_idx = m_idx - 1;
        end else begin
          m_result = m_code;
          m_busy = 0;
        end
      end else if (start_i) begin
        m_busy = 1;
        m_idx = W - 1;
        m_code = 1 << (W - 1);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Compare every output against the model away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R7 ready", int'(ready_o), m_busy ? 0 : 1);
      check("R2 dac code", int'(dac_code_o), m_code);
      check("R9 data bus", int'(data_o), m_data);
      check("R4 serial valid", int'(serial_valid_o), m_sv);
      if (m_sv != 0) check("R5 serial bit", int'(serial_bit_o), m_sb);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wait_idle();
    while (!ready_o) @(negedge clk);
  endtask

  // Start, count low-ready cycles, then read back the result
  task automatic convert(input logic [W-1:0] t, input int extra_start_at);
    int n;
    wait_idle();
    target = t;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R1 first trial", int'(dac_code_o), 1 << (W - 1));
    n = 0;
    while (!ready_o) begin
      n++;
      start_i = (n == extra_start_at);
      @(negedge clk);
      start_i = 1'b0;
    end
    check("R3 conversion length", n, W);
    check("R2 final code", int'(dac_code_o), int'(t));
    @(negedge clk);
    check("R6 no restart", int'(ready_o), 1);
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    check("R9 read result", int'(data_o), int'(t));
    @(negedge clk);
    check("R9 bus released", int'(data_o), 0);
  endtask

  initial begin
    @(negedge clk);
    check("R10 reset ready", int'(ready_o), 1);
    check("R10 reset dac", int'(dac_code_o), 0);
    check("R10 reset data", int'(data_o), 0);
    check("R10 reset serial valid", int'(serial_valid_o), 0);
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    convert(8'd0, 0);
    convert(8'd255, 0);
    convert(8'd128, 0);
    convert(8'd127, 0);
    convert(8'h55, 3);   // R6: start in mid-conversion
    convert(8'hAA, W);   // R6: start on the final decision edge
    for (int i = 0; i < 20; i++) convert(8'((i * 73 + 19) % 256), 0);

    // R8: result holds across idle time and a new target
    target = 8'd3;
    repeat (5) @(negedge clk);
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    check("R8 result held", int'(data_o), (19 * 73 + 19) % 256);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule